// File: doc/BRIEF.md
# Field Memory Read-Lag Classifier

This block watches the two ports of a field memory from one sampled clock domain. It sees four strobes: a write-pointer reset, a write-active cycle, a read-pointer reset and a read-active cycle. It counts how many active write cycles have gone by since the last write-pointer reset. When a read-pointer reset arrives, it uses that count to decide which field the read pass that is starting will return: the field written before the last write reset (old), the field being written now (new), or a mixture that cannot be relied on (undefined).

The verdict is held on a two-bit output until the next read-pointer reset. An undefined verdict raises a one-cycle error pulse. After a new-field verdict, the block keeps tracking the read-to-write distance cycle by cycle. It pulses the error line once if reads draw closer to writes than the new-field threshold. Write traffic is never blocked or changed. The block only observes, so it can serve as a protocol checker in simulation or as a scheduling aid in a video pipeline.

Top module: `fld_lag_classifier`

## Requirements
- R1: After synchronous reset, `cls_o` is 2'b00 (no verdict) and `err_o` is 0.
- R2: The lag is the number of cycles with `wr_act_i` high that fall strictly after the most recent `wr_rst_i` cycle and strictly before the `rd_rst_i` cycle. Write activity in the write-reset cycle is not counted. A write reset and a read reset in the same cycle give a lag of 0.
- R3: A lag below OLD_BELOW (default 70) gives the old-field code 2'b01, with no error pulse.
- R4: A lag from OLD_BELOW to NEW_FROM-1 (default 70 to 599, both ends included) gives the undefined code 2'b10. `err_o` is high for exactly the one cycle that follows the read-reset edge.
- R5: A lag of NEW_FROM (default 600) or more gives the new-field code 2'b11, with no error pulse.
- R6: A read reset with no write reset since the block reset gives 2'b10 and an error pulse.
- R7: The verdict appears on `cls_o` right after the clock edge that samples `rd_rst_i`. It then stays unchanged, whatever the write port does, until the next read reset.
- R8: While the verdict is 2'b11, a running distance starts at the sampled lag. It rises by one on each write-active cycle that is not a write reset and falls by one on each read-active cycle. When it would drop below NEW_FROM, `err_o` pulses once for one cycle, `cls_o` stays 2'b11, and no further distance error follows until the next read reset.
- R9: While the verdict is 2'b11, cycles with both ports active together leave the distance unchanged and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_rst_i | input | 1 | Write-pointer reset event |
| wr_act_i | input | 1 | Write-port active cycle |
| rd_rst_i | input | 1 | Read-pointer reset event |
| rd_act_i | input | 1 | Read-port active cycle |
| cls_o | output | 2 | Field verdict: 00 none, 01 old, 10 undefined, 11 new |
| err_o | output | 1 | One-cycle pulse on an undefined verdict or on distance erosion |

## Verification
A lag counter that drifts by even one count shows up at the first read reset near a threshold. Examples are a counted write-reset cycle or a miscounted same-cycle reset: the verdict at lags 69/70 and 599/600 flips one cycle after the read-reset edge. A distance tracker that is wrong shows up either as a missing error pulse on the first read that breaks the threshold, or as a spurious pulse during balanced traffic, within one cycle of the offending strobe. A verdict register that is not properly held shows up as a changed code during a long write-only stretch after a classification.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

    typedef enum logic [1:0] {
        FC_NONE  = 2'b00,
        FC_OLD   = 2'b01,
        FC_UNDEF = 2'b10,
        FC_NEW   = 2'b11
    } fld_cls_e;

    typedef struct packed {
        logic rst;
        logic act;
    } port_ev_t;

    // Map a sampled lag to a field verdict; no write reset seen -> undefined.
    function automatic fld_cls_e classify_lag(
        input logic [31:0] lag,
        input logic [31:0] old_below,
        input logic [31:0] new_from,
        input logic        seen
    );
        fld_cls_e res;
        if (!seen)                res = FC_UNDEF;
        else if (lag < old_below) res = FC_OLD;
        else if (lag >= new_from) res = FC_NEW;
        else                      res = FC_UNDEF;
        return res;
    endfunction

endpackage

// File: rtl/fdc_lag_counter.sv
module fdc_lag_counter
    import fdc_pkg::*;
#(
    parameter int unsigned CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  port_ev_t      wr,
    output logic [CW-1:0] lag_now,
    output logic          seen_now
);
    localparam logic [CW-1:0] LAG_MAX = '1;

    logic [CW-1:0] cnt_q;
    logic          seen_q;

    // A write reset in this cycle means the lag seen now is zero.
    assign lag_now  = wr.rst ? '0 : cnt_q;
    assign seen_now = wr.rst | seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (wr.rst) begin
            cnt_q  <= '0;
            seen_q <= 1'b1;
        end else if (wr.act && (cnt_q != LAG_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/fdc_classifier.sv
module fdc_classifier
    import fdc_pkg::*;
#(
    parameter int unsigned CW        = 12,
    parameter int unsigned OLD_BELOW = 70,
    parameter int unsigned NEW_FROM  = 600
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_rst,
    input  logic [CW-1:0] lag_now,
    input  logic          seen_now,
    output fld_cls_e      verdict,
    output fld_cls_e      cls_q,
    output logic          err_q
);
    assign verdict = classify_lag(32'(lag_now), 32'(OLD_BELOW),
                                  32'(NEW_FROM), seen_now);

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q <= FC_NONE;
            err_q <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (rd_rst) begin
                cls_q <= verdict;
                err_q <= (verdict == FC_UNDEF);
            end
        end
    end
endmodule

// File: rtl/fdc_drift.sv
module fdc_drift
    import fdc_pkg::*;
#(
    parameter int unsigned CW       = 12,
    parameter int unsigned NEW_FROM = 600
) (
    input  logic          clk,
    input  logic          rst,
    input  port_ev_t      wr,
    input  port_ev_t      rd,
    input  logic [CW-1:0] lag_now,
    input  logic          arm_load,
    output logic          err_q
);
    localparam logic [CW:0] DIST_MAX = {1'b0, {CW{1'b1}}};
    localparam logic [CW:0] NEW_W    = (CW+1)'(NEW_FROM);

    logic          armed_q;
    logic [CW-1:0] dist_q;
    logic [CW:0]   dist_sum;
    logic [CW:0]   dist_nx;

    // Distance never goes below NEW_FROM while armed, so no underflow.
    always_comb begin
        dist_sum = {1'b0, dist_q};
        if (wr.act && !wr.rst) dist_sum = dist_sum + 1'b1;
        if (rd.act)            dist_sum = dist_sum - 1'b1;
        dist_nx = (dist_sum > DIST_MAX) ? DIST_MAX : dist_sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            dist_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (rd.rst) begin
                armed_q <= arm_load;
                dist_q  <= lag_now;
            end else if (armed_q) begin
                if (dist_nx < NEW_W) begin
                    err_q   <= 1'b1;
                    armed_q <= 1'b0;
                end else begin
                    dist_q <= dist_nx[CW-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/fld_lag_classifier.sv
module fld_lag_classifier
    import fdc_pkg::*;
#(
    parameter int unsigned CW        = 12,
    parameter int unsigned OLD_BELOW = 70,
    parameter int unsigned NEW_FROM  = 600
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_rst_i,
    input  logic       wr_act_i,
    input  logic       rd_rst_i,
    input  logic       rd_act_i,
    output logic [1:0] cls_o,
    output logic       err_o
);
    port_ev_t      wr_ev;
    port_ev_t      rd_ev;
    logic [CW-1:0] lag_now;
    logic          seen_now;
    fld_cls_e      verdict;
    fld_cls_e      cls_q;
    logic          err_cls;
    logic          err_drift;

    assign wr_ev = '{rst: wr_rst_i, act: wr_act_i};
    assign rd_ev = '{rst: rd_rst_i, act: rd_act_i};

    fdc_lag_counter #(.CW(CW)) u_lag (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_ev),
        .lag_now  (lag_now),
        .seen_now (seen_now)
    );

    fdc_classifier #(.CW(CW), .OLD_BELOW(OLD_BELOW), .NEW_FROM(NEW_FROM)) u_cls (
        .clk      (clk),
        .rst      (rst),
        .rd_rst   (rd_rst_i),
        .lag_now  (lag_now),
        .seen_now (seen_now),
        .verdict  (verdict),
        .cls_q    (cls_q),
        .err_q    (err_cls)
    );

    fdc_drift #(.CW(CW), .NEW_FROM(NEW_FROM)) u_drift (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_ev),
        .rd       (rd_ev),
        .lag_now  (lag_now),
        .arm_load (verdict == FC_NEW),
        .err_q    (err_drift)
    );

    assign cls_o = cls_q;
    assign err_o = err_cls | err_drift;
endmodule

// File: rtl/fdc_checker.sv
module fdc_checker
    import fdc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       rd_rst_i,
    input logic [1:0] cls_o,
    input logic       err_o
);
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cls_o == 2'b00 && !err_o));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !rd_rst_i |=> $stable(cls_o));

    p_verdict_set_r7: assert property (@(posedge clk) disable iff (rst)
        rd_rst_i |=> (cls_o != 2'b00));

    p_undef_err_r4: assert property (@(posedge clk) disable iff (rst)
        rd_rst_i |=> ((cls_o == 2'b10) == err_o));

    p_old_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (err_o && cls_o == 2'b01) |-> 1'b0);

    p_drift_cause_r8: assert property (@(posedge clk) disable iff (rst)
        (err_o && !$past(rd_rst_i)) |-> (cls_o == 2'b11));
endmodule

bind fld_lag_classifier fdc_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_rst_i (rd_rst_i),
    .cls_o    (cls_o),
    .err_o    (err_o)
);

// File: tb/fld_lag_classifier_bench.sv
`timescale 1ns/1ps
module fld_lag_classifier_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_rst = 1'b0, wr_act = 1'b0, rd_rst = 1'b0, rd_act = 1'b0;
    logic [1:0] cls;
    logic       err;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int         at;
        logic [1:0] cls;
        logic       err;
        string      req;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fld_lag_classifier u_fld_lag_classifier (
        .clk(clk), .rst(rst),
        .wr_rst_i(wr_rst), .wr_act_i(wr_act),
        .rd_rst_i(rd_rst), .rd_act_i(rd_act),
        .cls_o(cls), .err_o(err)
    );

    // Monitor: compare outputs against queued expectations.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (cls !== e.cls || err !== e.err) begin
                failures++;
                $display("FAIL %s: cls=%b err=%b expected cls=%b err=%b",
                         e.req, cls, err, e.cls, e.err);
            end
        end
    end

    task automatic step(input logic wr_r, input logic wa,
                        input logic rr, input logic ra);
        @(negedge clk);
        wr_rst = wr_r; wr_act = wa; rd_rst = rr; rd_act = ra;
    endtask

    task automatic expect_at(input int d, input logic [1:0] c,
                             input logic e, input string req);
        exp_t x;
        x.at = cyc + d; x.cls = c; x.err = e; x.req = req;
        q.push_back(x);
    endtask

    // Write reset, n write-active cycles, read reset; check verdict and pulse end.
    task automatic run_lag(input int n, input logic wa_in_reset,
                           input logic [1:0] c, input logic e, input string req);
        step(1'b1, wa_in_reset, 1'b0, 1'b0);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        expect_at(1, c, e, req);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        expect_at(1, c, 1'b0, req);
        step(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        expect_at(0, 2'b00, 1'b0, "R1");
        step(1'b0, 1'b0, 1'b0, 1'b0);

        // R6: read reset before any write reset
        step(1'b0, 1'b0, 1'b1, 1'b0);
        expect_at(1, 2'b10, 1'b1, "R6");
        step(1'b0, 1'b0, 1'b0, 1'b0);
        expect_at(1, 2'b10, 1'b0, "R6");

        // R2: simultaneous resets give lag 0 -> old
        step(1'b1, 1'b0, 1'b1, 1'b0);
        expect_at(1, 2'b01, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b0, 1'b0);

        // R3: lag 69 old; R2: write-active in reset cycle not counted
        run_lag(69, 1'b0, 2'b01, 1'b0, "R3");
        run_lag(69, 1'b1, 2'b01, 1'b0, "R2");

        // R7: verdict held over many write cycles
        for (int k = 0; k < 7; k++) begin
            for (int i = 0; i < 100; i++) step(1'b0, 1'b1, 1'b0, 1'b0);
            expect_at(1, 2'b01, 1'b0, "R7");
        end
        step(1'b1, 1'b0, 1'b0, 1'b0);
        expect_at(1, 2'b01, 1'b0, "R7");

        // R4: undefined window edges
        run_lag(70, 1'b0, 2'b10, 1'b1, "R4");
        run_lag(71, 1'b0, 2'b10, 1'b1, "R4");
        run_lag(599, 1'b0, 2'b10, 1'b1, "R4");

        // R5: new field
        run_lag(1000, 1'b0, 2'b11, 1'b0, "R5");
        run_lag(600, 1'b0, 2'b11, 1'b0, "R5");

        // R9: balanced traffic at distance 600
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 1'b1, 1'b0, 1'b1);
            expect_at(1, 2'b11, 1'b0, "R9");
        end
        // R8: one extra read erodes the distance below 600
        step(1'b0, 1'b0, 1'b0, 1'b1);
        expect_at(1, 2'b11, 1'b1, "R8");
        step(1'b0, 1'b0, 1'b0, 1'b1);
        expect_at(1, 2'b11, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b0, 1'b1);
        expect_at(1, 2'b11, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b0, 1'b0);

        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule